// File: doc/BRIEF.md
# Low-Confidence Branch Skip Controller

This block sits beside the decode stage and decides whether a branch whose prediction is unreliable should be stepped over rather than predicted. When the branch is stepped over, the front end jumps straight to the point where both paths of the branch meet again. The skipped instructions run later, once the branch resolves. The controller keeps one small saturating confidence counter per branch slot. It also keeps a direct-mapped, tagged table of skip descriptors indexed by the branch address. Each descriptor holds the meeting-point address, the number of instructions the skipped region is expected to contain, and two register masks. One mask lists the registers the skipped code reads from the main flow. The other lists the registers the skipped code hands back to it.

A lookup presents a branch address. One cycle later the block reports whether to skip. On a skip it also reports the meeting-point address, the instruction gap the downstream logic must reserve, and both register masks. Descriptors are learned from the retire stream. A mispredicted branch writes its descriptor. Its meeting point is the fall-through address for a backward branch, or the destination of the jump just ahead of the taken target for a forward branch. A correctly predicted branch only raises its confidence. Descriptor contents are hints and are never checked at lookup.

Top module: `skip_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after it, skip_o is 0 and rcv_pc_o, gap_o, in_mask_o and out_mask_o are all zero. After reset no address hits the descriptor table. Whenever skip_o is 0, those four outputs are zero.
- R2: Each branch slot has a 4-bit confidence counter, selected by pc bits [7:2]. A retired mispredicted branch clears it to 0. A retired correct branch increments it, and it stays at 15 once it reaches 15.
- R3: A skip is granted only when the slot's confidence is strictly below thresh_i. With thresh_i = 0 no skip is ever granted.
- R4: The descriptor table has 128 entries, selected by pc bits [8:2] and tagged with pc bits [31:9]. A lookup hits only when the entry is valid and its tag matches. Writing a different branch into the same entry evicts the old one.
- R5: For a mispredicted branch whose target is above its own address (forward), the stored meeting point is rt_jump_tgt_i.
- R6: For a mispredicted branch whose target is at or below its own address (backward), the stored meeting point is rt_pc_i + 4.
- R7: A skip is refused when the stored instruction count exceeds 64. A count of exactly 64 is granted. gap_o never exceeds 64.
- R8: Outputs are registered. They reflect the lookup presented in the previous cycle, and skip_o is 0 in any cycle that follows a cycle with lk_valid_i low.
- R9: On a granted skip, gap_o equals the stored count, and in_mask_o and out_mask_o equal the masks learned at retire.
- R10: Retiring a correctly predicted branch leaves its descriptor unchanged, whatever values are on the other retire fields.
- R11: A lookup in the same cycle as a retire update sees the table and counter contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thresh_i | input | 4 | Confidence threshold; skip allowed when counter < threshold |
| lk_valid_i | input | 1 | Lookup request from decode |
| lk_pc_i | input | 32 | Address of the branch being decoded |
| rt_valid_i | input | 1 | A branch retires this cycle |
| rt_pc_i | input | 32 | Address of the retiring branch |
| rt_mispred_i | input | 1 | Retiring branch was mispredicted |
| rt_target_i | input | 32 | Taken target of the retiring branch |
| rt_jump_tgt_i | input | 32 | Destination of the jump located just before the taken target |
| rt_skip_cnt_i | input | 8 | Observed length of the skipped region, in instructions |
| rt_in_mask_i | input | 32 | Registers the skipped region reads from the main flow |
| rt_out_mask_i | input | 32 | Registers the skipped region produces for the main flow |
| skip_o | output | 1 | Skip granted for the previous lookup |
| rcv_pc_o | output | 32 | Meeting-point address to fetch from |
| gap_o | output | 7 | Instruction gap to reserve |
| in_mask_o | output | 32 | Input register mask of the skipped region |
| out_mask_o | output | 32 | Output register mask of the skipped region |

## Verification
A corrupted confidence counter appears in the very next lookup of that branch. The threshold at which skip_o switches shifts, so a sweep of every threshold against every counter value from 0 to beyond saturation pins the counter down exactly. A wrong index, tag or valid bit appears one cycle after the lookup, either as a skip for a branch never learned or as a missing skip for one just written. A wrong direction decision or count limit shows up as a wrong rcv_pc_o, or as skip_o at counts just around 64. Those outputs are visible in the cycle after the lookup.

// File: rtl/skip_pkg.sv
package skip_pkg;
  localparam int PC_W      = 32;
  localparam int REG_N     = 32;
  localparam int CNT_W     = 8;
  localparam int TBL_N     = 128;
  localparam int TBL_IW    = $clog2(TBL_N);
  localparam int TAG_W     = PC_W - TBL_IW - 2;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [PC_W-1:0]  rcv_pc;
    logic [CNT_W-1:0] cnt;
    logic [REG_N-1:0] in_mask;
    logic [REG_N-1:0] out_mask;
  } skip_entry_t;
endpackage

// File: rtl/skip_conf_table.sv
module skip_conf_table #(
  parameter int N = 64,
  parameter int W = 4,
  parameter int PC_W = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PC_W-1:0] rd_pc_i,
  output logic [W-1:0]  rd_conf_o,
  input  logic          up_valid_i,
  input  logic [PC_W-1:0] up_pc_i,
  input  logic          up_mispred_i
);
  localparam int IW = $clog2(N);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0]  cnt_q [N];
  logic [IW-1:0] rd_idx, up_idx;
  logic          unused_pc;

  assign rd_idx    = rd_pc_i[IW+1:2];
  assign up_idx    = up_pc_i[IW+1:2];
  assign unused_pc = ^{rd_pc_i[PC_W-1:IW+2], rd_pc_i[1:0], up_pc_i[PC_W-1:IW+2], up_pc_i[1:0]};
  assign rd_conf_o = cnt_q[rd_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) cnt_q[i] <= '0;
    end else if (up_valid_i) begin
      if (up_mispred_i)             cnt_q[up_idx] <= '0;
      else if (cnt_q[up_idx] != MAXV) cnt_q[up_idx] <= cnt_q[up_idx] + 1'b1;
    end
  end

  AST_CONF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_valid_i && up_mispred_i |=> cnt_q[$past(up_idx)] == '0); // R2

  AST_CONF_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_valid_i && !up_mispred_i && cnt_q[up_idx] == MAXV |=> cnt_q[$past(up_idx)] == MAXV); // R2
endmodule

// File: rtl/skip_desc_table.sv
module skip_desc_table
  import skip_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PC_W-1:0]  rd_pc_i,
  output logic             rd_hit_o,
  output skip_entry_t      rd_entry_o,
  input  logic             wr_en_i,
  input  logic [PC_W-1:0]  wr_pc_i,
  input  skip_entry_t      wr_entry_i
);
  logic [TBL_N-1:0]  vld_q;
  skip_entry_t       ent_q [TBL_N];
  logic [TBL_IW-1:0] rd_idx, wr_idx;
  logic              unused_pc;

  assign rd_idx     = rd_pc_i[TBL_IW+1:2];
  assign wr_idx     = wr_pc_i[TBL_IW+1:2];
  assign unused_pc  = ^{rd_pc_i[1:0], wr_pc_i};
  assign rd_entry_o = ent_q[rd_idx];
  assign rd_hit_o   = vld_q[rd_idx] && (ent_q[rd_idx].tag == rd_pc_i[PC_W-1:TBL_IW+2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < TBL_N; i++) ent_q[i] <= '0;
    end else if (wr_en_i) begin
      vld_q[wr_idx] <= 1'b1;
      ent_q[wr_idx] <= wr_entry_i;
    end
  end

  AST_ALLOC_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> vld_q[$past(wr_idx)]); // R4

  AST_ALLOC_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ent_q[$past(wr_idx)].tag == $past(wr_pc_i[PC_W-1:TBL_IW+2])); // R4
endmodule

// File: rtl/skip_ctrl.sv
module skip_ctrl
  import skip_pkg::*;
#(
  parameter int CONF_N  = 64,
  parameter int CONF_W  = 4,
  parameter int MAX_GAP = 64,
  localparam int GAP_W  = $clog2(MAX_GAP + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CONF_W-1:0] thresh_i,
  input  logic              lk_valid_i,
  input  logic [PC_W-1:0]   lk_pc_i,
  input  logic              rt_valid_i,
  input  logic [PC_W-1:0]   rt_pc_i,
  input  logic              rt_mispred_i,
  input  logic [PC_W-1:0]   rt_target_i,
  input  logic [PC_W-1:0]   rt_jump_tgt_i,
  input  logic [CNT_W-1:0]  rt_skip_cnt_i,
  input  logic [REG_N-1:0]  rt_in_mask_i,
  input  logic [REG_N-1:0]  rt_out_mask_i,
  output logic              skip_o,
  output logic [PC_W-1:0]   rcv_pc_o,
  output logic [GAP_W-1:0]  gap_o,
  output logic [REG_N-1:0]  in_mask_o,
  output logic [REG_N-1:0]  out_mask_o
);
  logic [CONF_W-1:0] conf;
  logic              hit, go, wr_en, backward;
  skip_entry_t       rd_ent, wr_ent;

  skip_conf_table #(.N(CONF_N), .W(CONF_W), .PC_W(PC_W)) i_conf (
    .clk_i, .rst_ni,
    .rd_pc_i      (lk_pc_i),
    .rd_conf_o    (conf),
    .up_valid_i   (rt_valid_i),
    .up_pc_i      (rt_pc_i),
    .up_mispred_i (rt_mispred_i)
  );

  // learn on mispredict; meeting point chosen by branch direction
  assign wr_en    = rt_valid_i && rt_mispred_i;
  assign backward = rt_target_i <= rt_pc_i;

  always_comb begin
    wr_ent          = '0;
    wr_ent.tag      = rt_pc_i[PC_W-1:TBL_IW+2];
    wr_ent.rcv_pc   = backward ? rt_pc_i + PC_W'(4) : rt_jump_tgt_i;
    wr_ent.cnt      = rt_skip_cnt_i;
    wr_ent.in_mask  = rt_in_mask_i;
    wr_ent.out_mask = rt_out_mask_i;
  end

  skip_desc_table i_desc (
    .clk_i, .rst_ni,
    .rd_pc_i    (lk_pc_i),
    .rd_hit_o   (hit),
    .rd_entry_o (rd_ent),
    .wr_en_i    (wr_en),
    .wr_pc_i    (rt_pc_i),
    .wr_entry_i (wr_ent)
  );

  assign go = lk_valid_i && hit && (conf < thresh_i) && (rd_ent.cnt <= CNT_W'(MAX_GAP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      skip_o     <= 1'b0;
      rcv_pc_o   <= '0;
      gap_o      <= '0;
      in_mask_o  <= '0;
      out_mask_o <= '0;
    end else begin
      skip_o     <= go;
      rcv_pc_o   <= go ? rd_ent.rcv_pc : '0;
      gap_o      <= go ? GAP_W'(rd_ent.cnt) : '0;
      in_mask_o  <= go ? rd_ent.in_mask : '0;
      out_mask_o <= go ? rd_ent.out_mask : '0;
    end
  end

  AST_GAP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> gap_o <= GAP_W'(MAX_GAP)); // R7

  AST_SKIP_NEEDS_LOOKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> $past(lk_valid_i)); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !skip_o |-> (rcv_pc_o == '0 && gap_o == '0 && in_mask_o == '0 && out_mask_o == '0)); // R1

  AST_ZERO_THRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(thresh_i) == '0 |-> !skip_o); // R3
endmodule

// File: tb/test_skip_ctrl.sv
`timescale 1ns/1ps
module test_skip_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  thresh_i = '0;
  logic        lk_valid_i = 1'b0;
  logic [31:0] lk_pc_i = '0;
  logic        rt_valid_i = 1'b0;
  logic [31:0] rt_pc_i = '0;
  logic        rt_mispred_i = 1'b0;
  logic [31:0] rt_target_i = '0;
  logic [31:0] rt_jump_tgt_i = '0;
  logic [7:0]  rt_skip_cnt_i = '0;
  logic [31:0] rt_in_mask_i = '0;
  logic [31:0] rt_out_mask_i = '0;
  logic        skip_o;
  logic [31:0] rcv_pc_o;
  logic [6:0]  gap_o;
  logic [31:0] in_mask_o, out_mask_o;

  int vectors = 0;
  int fails = 0;

  always #4 clk_i = ~clk_i;

  skip_ctrl i_skip_ctrl (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic retire(input logic [31:0] pc, input logic misp, input logic [31:0] tgt,
                        input logic [31:0] jt, input logic [7:0] cnt,
                        input logic [31:0] im, input logic [31:0] om);
    rt_valid_i = 1'b1; rt_pc_i = pc; rt_mispred_i = misp; rt_target_i = tgt;
    rt_jump_tgt_i = jt; rt_skip_cnt_i = cnt; rt_in_mask_i = im; rt_out_mask_i = om;
    @(negedge clk_i);
    rt_valid_i = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] pc);
    lk_valid_i = 1'b1; lk_pc_i = pc;
    @(negedge clk_i);
    lk_valid_i = 1'b0;
  endtask

  initial begin
    #(8ns * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    @(negedge clk_i);
    chk("R1 skip in reset", skip_o, 0);
    chk("R1 rcv in reset", rcv_pc_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 gap after reset", gap_o, 0);
    chk("R1 masks after reset", {in_mask_o, out_mask_o}, 0);
    thresh_i = 4'd15;
    lookup(32'h1040);
    chk("R1 empty table no skip", skip_o, 0);

    // R2 R3 R5 R9 R10: sweep counter value against every threshold
    retire(32'h1040, 1, 32'h1080, 32'h10C0, 8'd10, 32'h0000_00F0, 32'h0000_0F00);
    for (int k = 0; k < 18; k++) begin
      for (int t = 0; t < 16; t++) begin
        automatic int conf = (k > 15) ? 15 : k;
        automatic bit exp = conf < t;
        thresh_i = 4'(t);
        lookup(32'h1040);
        chk("R2/R3 skip vs confidence", skip_o, exp);
        if (exp) begin
          chk("R5 forward meeting point", rcv_pc_o, 32'h10C0);
          chk("R9 gap", gap_o, 10);
          chk("R9 masks", {in_mask_o, out_mask_o}, {32'h0000_00F0, 32'h0000_0F00});
        end
      end
      // R10: correct retire with different fields must not touch the descriptor
      retire(32'h1040, 0, 32'h1000, 32'hDEAD0, 8'd99, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    end
    retire(32'h1040, 1, 32'h1080, 32'h10C0, 8'd10, 32'h0000_00F0, 32'h0000_0F00);
    thresh_i = 4'd1;
    lookup(32'h1040);
    chk("R2 mispredict clears counter", skip_o, 1);
    thresh_i = 4'd0;
    lookup(32'h1040);
    chk("R3 zero threshold", skip_o, 0);

    // R6 backward branches, including target equal to pc
    thresh_i = 4'd1;
    retire(32'h2000, 1, 32'h1F00, 32'h5550, 8'd5, 32'h3, 32'h4);
    lookup(32'h2000);
    chk("R6 backward skip", skip_o, 1);
    chk("R6 backward meeting point", rcv_pc_o, 32'h2004);
    retire(32'h2000, 1, 32'h2000, 32'h5550, 8'd5, 32'h3, 32'h4);
    lookup(32'h2000);
    chk("R6 self-loop meeting point", rcv_pc_o, 32'h2004);

    // R7 count limit sweep
    for (int c = 60; c <= 70; c++) begin
      retire(32'h3084, 1, 32'h3100, 32'h3200, 8'(c), 32'h1, 32'h2);
      lookup(32'h3084);
      chk("R7 count limit skip", skip_o, c <= 64);
      chk("R7 count limit gap", gap_o, (c <= 64) ? c : 0);
    end

    // R4 tag match and eviction
    lookup(32'h1640);
    chk("R4 tag mismatch no skip", skip_o, 0);
    retire(32'h1240, 1, 32'h1300, 32'h1400, 8'd7, 32'h8, 32'h9);
    lookup(32'h1240);
    chk("R4 new entry hit", skip_o, 1);
    chk("R4 new entry meeting point", rcv_pc_o, 32'h1400);
    lookup(32'h1040);
    chk("R4 evicted entry misses", skip_o, 0);

    // R11 same-cycle retire and lookup
    lk_valid_i = 1'b1; lk_pc_i = 32'h4108;
    retire(32'h4108, 1, 32'h4200, 32'h4300, 8'd3, 32'h5, 32'h6);
    lk_valid_i = 1'b0;
    chk("R11 lookup sees old state", skip_o, 0);
    lookup(32'h4108);
    chk("R11 next lookup sees update", skip_o, 1);

    // R8 no lookup, no skip; registered timing
    thresh_i = 4'd15;
    lk_pc_i = 32'h4108;
    @(negedge clk_i);
    chk("R8 idle lookup", skip_o, 0);
    lk_valid_i = 1'b1;
    #1;
    chk("R8 output not combinational", skip_o, 0);
    @(negedge clk_i);
    lk_valid_i = 1'b0;
    chk("R8 output one cycle later", skip_o, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule